// File: doc/BRIEF.md
# System Control Register Window

This block is a 4 KB window of system control words on a simple single-cycle memory-mapped bus. A bus access is one cycle with a valid strobe, a write enable, a 12-bit byte offset and a 32-bit write word. Read data comes back from a register one cycle after the read strobe. The window holds two general configuration words, one of them driving a row of LEDs. It also holds a clock-lock word that combines live lock inputs with a software lock mask, and fixed identification constants.

The block also fronts a configuration channel whose transaction engine lives elsewhere. It stores the outgoing data word itself. Reads of the channel control, channel status and returned data words come straight from the engine's inputs. Each write to the channel control word is passed to the engine as a one-cycle pulse with the written word.

Any access to an offset that no register occupies raises a one-cycle bad-access pulse. Misaligned offsets count as unoccupied. A read there returns zero, and a write there changes nothing.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, offsets 0x000 (general word A), 0x004 (LED word) and 0x0A4 (outgoing channel data) read 0. Offset 0x100 (lock word) reads 0xFFFF0001 while all lock inputs are 1.
- R2: Offsets 0x000, 0x004 and 0x0A4 store all 32 bits written. A read returns the stored value on `bus_rdata` in the cycle after the read strobe. `cfg0_out` and `chan_out_data` show the stored words A and outgoing data.
- R3: `led_out[i]` equals bit i of the LED word at 0x004 for i in 0..7. `led_out[7]` is the leftmost LED.
- R4: Offset 0x00C (switch word) always reads 0, and writes to it change nothing and raise no bad-access pulse.
- R5: In the lock word at 0x100, a write changes only bits [31:24] (the lock mask, reset 0xFF). Bits [23:16] read the current `dll_lock_in`, and bits [15:1] read 0.
- R6: Lock word bit 0 reads 1 exactly when every lock input whose mask bit is 1 is itself 1.
- R7: Offsets 0x010, 0xFF8 and 0xFFC read the parameters CFG4_VALUE, AID_VALUE and ID_VALUE. Writes to them are ignored.
- R8: Offsets 0x0A0 and 0x0AC read `chan_rtn_in` and `chan_stat_in`, and 0x0A8 reads `chan_ctrl_in`. Writes to 0x0A0 and 0x0AC are ignored and raise no `chan_ctrl_wr`.
- R9: A write to 0x0A8 makes `chan_ctrl_wr` 1 for exactly the next cycle, with `chan_ctrl_wdata` equal to the written word. No other access raises `chan_ctrl_wr`.
- R10: An access to any offset other than the eleven listed, misaligned offsets included, makes `bad_access` 1 for exactly the next cycle. A read there returns 0, and a write there changes no register.
- R11: `bus_rdata` keeps its value in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, valid the cycle after a read |
| bad_access | output | 1 | One-cycle pulse after an unmapped access |
| led_out | output | 8 | LED drive, bit 7 leftmost |
| cfg0_out | output | 32 | General word A |
| dll_lock_in | input | 8 | Per-clock lock flags |
| chan_out_data | output | 32 | Outgoing channel data word |
| chan_ctrl_wr | output | 1 | Pulse on a channel control write |
| chan_ctrl_wdata | output | 32 | Word written to channel control |
| chan_ctrl_in | input | 32 | Engine's channel control value |
| chan_stat_in | input | 32 | Engine's channel status value |
| chan_rtn_in | input | 32 | Engine's returned data |

## Verification
The assertions assume that the lock inputs and the channel-engine inputs hold steady over the clock edge that samples a read. The stimulus changes them only at falling edges between accesses. The checks on read data also assume that only one access is in flight per cycle, with the strobe held for a single cycle. Random offsets are drawn both from the mapped set and from the whole 12-bit space, misaligned values included, so that decoded and undecoded paths are both exercised.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   typedef enum logic [3:0] {
      RG_CFG0, RG_CFG1, RG_CFG3, RG_CFG4, RG_RTN, RG_OUT,
      RG_CTRL, RG_STAT, RG_DLL, RG_AID, RG_ID
   } reg_id_e;

   localparam int NUM_REGS = 11;
   localparam int WIN_AW   = 12;

   // Byte offset of each register; the software map depends on these values
   function automatic logic [WIN_AW-1:0] reg_offset(input int idx);
      case (idx)
         0:       return 12'h000;
         1:       return 12'h004;
         2:       return 12'h00C;
         3:       return 12'h010;
         4:       return 12'h0A0;
         5:       return 12'h0A4;
         6:       return 12'h0A8;
         7:       return 12'h0AC;
         8:       return 12'h100;
         9:       return 12'hFF8;
         default: return 12'hFFC;
      endcase
   endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                hit
);
   localparam int SELW = NUM_REGS;

   for (genvar g = 0; g < SELW; g++) begin : g_cmp
      assign sel[g] = (addr == reg_offset(g));
   end

   assign hit = |sel;
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
   parameter int         NUM_DLL    = 8,
   parameter logic [7:0] MASK_RESET = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mask_we,
   input  logic [7:0]         mask_wdata,
   input  logic [NUM_DLL-1:0] lock_in,
   output logic [31:0]        word
);
   localparam int SLOTS = 8;

   logic [SLOTS-1:0] mask_q;
   logic [SLOTS-1:0] lock_v;
   logic [SLOTS-1:0] ok;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= MASK_RESET;
      else if (mask_we) mask_q <= mask_wdata;
   end

   // Present slots report their input; absent slots read 0 and never block the summary
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_DLL) begin : g_live
         assign lock_v[i] = lock_in[i];
         assign ok[i]     = lock_in[i] | ~mask_q[i];
      end else begin : g_absent
         assign lock_v[i] = 1'b0;
         assign ok[i]     = 1'b1;
      end
   end

   assign word = {mask_q, lock_v, 15'd0, &ok};
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          NUM_LED    = 8,
   parameter int          NUM_DLL    = 8,
   parameter logic [31:0] CFG4_VALUE = 32'h0000_0000,
   parameter logic [31:0] AID_VALUE  = 32'h0000_0000,
   parameter logic [31:0] ID_VALUE   = 32'h0000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bad_access,
   output logic [NUM_LED-1:0] led_out,
   output logic [DATA_W-1:0]  cfg0_out,
   input  logic [NUM_DLL-1:0] dll_lock_in,
   output logic [DATA_W-1:0]  chan_out_data,
   output logic               chan_ctrl_wr,
   output logic [DATA_W-1:0]  chan_ctrl_wdata,
   input  logic [DATA_W-1:0]  chan_ctrl_in,
   input  logic [DATA_W-1:0]  chan_stat_in,
   input  logic [DATA_W-1:0]  chan_rtn_in
);
   localparam int MASK_LSB = DATA_W - 8;

   if (ADDR_W != WIN_AW) begin : g_chk_aw
      $error("sysctl_regs: ADDR_W must be 12");
   end
   if (DATA_W != 32) begin : g_chk_dw
      $error("sysctl_regs: DATA_W must be 32");
   end
   if (NUM_LED < 1 || NUM_LED > 8) begin : g_chk_led
      $error("sysctl_regs: NUM_LED must be 1..8");
   end
   if (NUM_DLL < 1 || NUM_DLL > 8) begin : g_chk_dll
      $error("sysctl_regs: NUM_DLL must be 1..8");
   end

   logic [NUM_REGS-1:0] sel;
   logic                hit;
   logic                wr, rd;
   logic [DATA_W-1:0]   cfg0_q, cfg1_q, out_q;
   logic [DATA_W-1:0]   lock_word;
   logic [DATA_W-1:0]   word [NUM_REGS];
   logic [DATA_W-1:0]   rd_val;

   sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .hit  (hit)
   );

   assign wr = bus_valid &  bus_write;
   assign rd = bus_valid & ~bus_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg0_q <= '0;
         cfg1_q <= '0;
         out_q  <= '0;
      end else begin
         if (wr && sel[RG_CFG0]) cfg0_q <= bus_wdata;
         if (wr && sel[RG_CFG1]) cfg1_q <= bus_wdata;
         if (wr && sel[RG_OUT])  out_q  <= bus_wdata;
      end
   end

   sysctl_lock #(.NUM_DLL(NUM_DLL), .MASK_RESET(8'hFF)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (wr & sel[RG_DLL]),
      .mask_wdata (bus_wdata[DATA_W-1:MASK_LSB]),
      .lock_in    (dll_lock_in),
      .word       (lock_word)
   );

   always_comb begin
      word[RG_CFG0] = cfg0_q;
      word[RG_CFG1] = cfg1_q;
      word[RG_CFG3] = '0;
      word[RG_CFG4] = CFG4_VALUE;
      word[RG_RTN]  = chan_rtn_in;
      word[RG_OUT]  = out_q;
      word[RG_CTRL] = chan_ctrl_in;
      word[RG_STAT] = chan_stat_in;
      word[RG_DLL]  = lock_word;
      word[RG_AID]  = AID_VALUE;
      word[RG_ID]   = ID_VALUE;
   end

   // One-hot select, so an OR of gated words forms the read mux
   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel[i]) rd_val = rd_val | word[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata       <= '0;
         bad_access      <= 1'b0;
         chan_ctrl_wr    <= 1'b0;
         chan_ctrl_wdata <= '0;
      end else begin
         if (rd) bus_rdata <= rd_val;
         bad_access   <= bus_valid & ~hit;
         chan_ctrl_wr <= wr & sel[RG_CTRL];
         if (wr && sel[RG_CTRL]) chan_ctrl_wdata <= bus_wdata;
      end
   end

   for (genvar l = 0; l < NUM_LED; l++) begin : g_led
      assign led_out[l] = cfg1_q[l];
   end

   assign cfg0_out      = cfg0_q;
   assign chan_out_data = out_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int NUM_LED = 8,
   parameter int NUM_DLL = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_valid,
   input logic               bus_write,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               bad_access,
   input logic [NUM_LED-1:0] led_out,
   input logic [NUM_DLL-1:0] dll_lock_in,
   input logic               chan_ctrl_wr,
   input logic [DATA_W-1:0]  chan_ctrl_wdata
);
   logic rd, wr;
   assign rd = bus_valid & ~bus_write;
   assign wr = bus_valid &  bus_write;

   // R9: channel control write gives a pulse with the written word
   a_r9_ctrl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == 12'h0A8) |=> (chan_ctrl_wr && chan_ctrl_wdata == $past(bus_wdata)));

   // R9: the pulse lasts a single cycle under a non-control access
   a_r9_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr != 12'h0A8) |=> !chan_ctrl_wr);

   // R3: LED word write reaches the LED pins
   a_r3_led: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == 12'h004) |=> (led_out == $past(bus_wdata[NUM_LED-1:0])));

   // R4: switch word reads zero
   a_r4_switch_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == 12'h00C) |=> (bus_rdata == '0 && !bad_access));

   // R5: lock word layout
   a_r5_lock_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == 12'h100) |=>
         (bus_rdata[15:1] == '0 && bus_rdata[16 +: NUM_DLL] == $past(dll_lock_in)));

   // R6: all inputs locked forces the summary bit
   a_r6_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == 12'h100 && &dll_lock_in) |=> bus_rdata[0]);

   // R10: a misaligned read is rejected and returns zero
   a_r10_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr[1:0] != 2'b00) |=> (bad_access && bus_rdata == '0));

   // R10: a pulse only follows an access
   a_r10_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !bad_access);

   // R11: read data holds without a read strobe
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(bus_rdata));
endmodule

bind sysctl_regs sysctl_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LED(NUM_LED), .NUM_DLL(NUM_DLL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bad_access(bad_access), .led_out(led_out), .dll_lock_in(dll_lock_in),
   .chan_ctrl_wr(chan_ctrl_wr), .chan_ctrl_wdata(chan_ctrl_wdata)
);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] P_CFG4 = 32'h4C0F_0004;
   localparam logic [31:0] P_AID  = 32'hA1D0_0102;
   localparam logic [31:0] P_ID   = 32'h1D00_7E57;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bad_access;
   logic [7:0]  led_out;
   logic [31:0] cfg0_out;
   logic [7:0]  dll_lock_in = 8'hFF;
   logic [31:0] chan_out_data;
   logic        chan_ctrl_wr;
   logic [31:0] chan_ctrl_wdata;
   logic [31:0] chan_ctrl_in = 32'h0010_0000;
   logic [31:0] chan_stat_in = '0;
   logic [31:0] chan_rtn_in  = '0;

   int n_checks = 0;
   int n_fail   = 0;

   // Bench model state
   logic [31:0] m_cfg0 = '0, m_cfg1 = '0, m_out = '0;
   logic [7:0]  m_mask = 8'hFF;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_regs #(.CFG4_VALUE(P_CFG4), .AID_VALUE(P_AID), .ID_VALUE(P_ID)) uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bad_access(bad_access), .led_out(led_out), .cfg0_out(cfg0_out),
      .dll_lock_in(dll_lock_in), .chan_out_data(chan_out_data),
      .chan_ctrl_wr(chan_ctrl_wr), .chan_ctrl_wdata(chan_ctrl_wdata),
      .chan_ctrl_in(chan_ctrl_in), .chan_stat_in(chan_stat_in),
      .chan_rtn_in(chan_rtn_in)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic mapped(input logic [11:0] a);
      case (a)
         12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0, 12'h0A4,
         12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h000: return m_cfg0;
         12'h004: return m_cfg1;
         12'h010: return P_CFG4;
         12'h0A0: return chan_rtn_in;
         12'h0A4: return m_out;
         12'h0A8: return chan_ctrl_in;
         12'h0AC: return chan_stat_in;
         12'h100: return {m_mask, dll_lock_in, 15'd0, &(dll_lock_in | ~m_mask)};
         12'hFF8: return P_AID;
         12'hFFC: return P_ID;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [11:0] a);
      case (a)
         12'h000, 12'h004, 12'h0A4: return "R2";
         12'h00C:                   return "R4";
         12'h010, 12'hFF8, 12'hFFC: return "R7";
         12'h0A0, 12'h0AC, 12'h0A8: return "R8";
         12'h100:                   return "R5/R6";
         default:                   return "R10";
      endcase
   endfunction

   task automatic do_read(input logic [11:0] a);
      logic [31:0] e;
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      e = exp_read(a);
      @(negedge clk);
      bus_valid = 1'b0;
      check(req_of(a), bus_rdata, e);
      check("R10 bad pulse", {31'd0, bad_access}, {31'd0, ~mapped(a)});
      check("R9 no ctrl pulse on read", {31'd0, chan_ctrl_wr}, 32'd0);
      @(negedge clk);
      check("R11 rdata hold", bus_rdata, e);
      check("R10 pulse one cycle", {31'd0, bad_access}, 32'd0);
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      case (a)
         12'h000: m_cfg0 = d;
         12'h004: m_cfg1 = d;
         12'h0A4: m_out  = d;
         12'h100: m_mask = d[31:24];
         default: ;
      endcase
      @(negedge clk);
      bus_valid = 1'b0;
      check("R10 bad pulse on write", {31'd0, bad_access}, {31'd0, ~mapped(a)});
      check("R9 ctrl pulse", {31'd0, chan_ctrl_wr}, {31'd0, a == 12'h0A8});
      if (a == 12'h0A8) check("R9 ctrl data", chan_ctrl_wdata, d);
      check("R3 leds", {24'd0, led_out}, {24'd0, m_cfg1[7:0]});
      check("R2 cfg0_out", cfg0_out, m_cfg0);
      check("R2 chan_out_data", chan_out_data, m_out);
      @(negedge clk);
      check("R9 ctrl pulse one cycle", {31'd0, chan_ctrl_wr}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [11:0] map_tab [11] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0,
                                    12'h0A4, 12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC};
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1 rdata after reset", bus_rdata, 32'h0);
      check("R1 bad_access after reset", {31'd0, bad_access}, 32'd0);
      check("R1 leds after reset", {24'd0, led_out}, 32'd0);
      do_read(12'h000);
      do_read(12'h004);
      do_read(12'h0A4);
      do_read(12'h100);
      check("R1 lock word reset", bus_rdata, 32'hFFFF_0001);

      // Directed corners
      do_write(12'h004, 32'h0000_0081);  // R3 leftmost and rightmost LEDs
      check("R3 leftmost led", {31'd0, led_out[7]}, 32'd1);
      do_write(12'h00C, 32'hFFFF_FFFF);  // R4
      do_read(12'h00C);
      do_write(12'hFF8, 32'h1234_5678);  // R7
      do_read(12'hFF8);
      do_write(12'h0AC, 32'hDEAD_BEEF);  // R8
      do_write(12'h0A0, 32'hDEAD_BEEF);
      do_read(12'h0A0);
      do_write(12'h100, 32'h0000_FFFF);  // R5 mask cleared; low bits ignored
      dll_lock_in = 8'h00;
      do_read(12'h100);
      check("R6 empty mask summary", {31'd0, bus_rdata[0]}, 32'd1);
      do_write(12'h100, 32'h01FF_FFFF);
      dll_lock_in = 8'hFE;
      do_read(12'h100);
      check("R6 masked unlocked summary", {31'd0, bus_rdata[0]}, 32'd0);
      do_write(12'h002, 32'hFFFF_FFFF);  // R10 misaligned
      do_read(12'h002);
      do_write(12'h800, 32'hCAFE_F00D);
      do_read(12'h000);                  // R10 unmapped write left word A intact
      do_write(12'h0A8, 32'h8010_0003);  // R9

      // Constrained random traffic
      for (int k = 0; k < 600; k++) begin
         logic [11:0] a;
         logic [31:0] d;
         if ($urandom_range(3) != 0) a = map_tab[$urandom_range(10)];
         else                        a = 12'($urandom);
         d = $urandom;
         dll_lock_in  = 8'($urandom);
         chan_stat_in = $urandom;
         chan_rtn_in  = $urandom;
         chan_ctrl_in = $urandom;
         if ($urandom_range(1) == 1) do_write(a, d);
         else                        do_read(a);
      end

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule